// File: doc/BRIEF.md
# DMA channel transfer engine

A single memory-to-memory DMA channel. Software loads a source address, a destination address, a unit count and a control word through a small indexed register port. Once the enable bit is set, the channel raises its own transfer requests with no external trigger. It asks for the bus and moves each unit as a read from the source followed by a write to the destination. After every unit it steps both addresses and decrements the count.

The unit is 1, 2 or 4 bytes, or a 16-byte unit moved as four 4-byte read/write pairs. A control bit selects the bus-holding policy:
- **Cycle-stealing:** the bus request is dropped after every unit and the bus must be won again for the next one.
- **Burst:** the bus is kept until the count runs out.

Sticky status bits mark the halfway point, the end of the transfer and a misaligned start. Each of the first two can drive an interrupt line.

Bus data is right-justified on a 32-bit data path. An access is held with `bus_valid_o` until the cycle in which `bus_ready_i` is high. `bus_size_o` gives the access width: 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every register reads 0, `bus_req_o`, `bus_valid_o`, `irq_half_o` and `irq_done_o` are low.
- R2: Each unit is one read from the source then one write of the same data to the destination. CTRL[2:1] (CTRL is register index 3) gives the unit: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 16 bytes. A 16-byte unit is four read/write pairs of 4 bytes at offsets 0, 4, 8 and 12.
- R3: SRC (index 0) and DST (index 1) each step once per unit by the unit size. CTRL[4:3] selects the source mode and CTRL[6:5] the destination mode: 0 fixed, 1 increment, 2 decrement, 3 fixed.
- R4: CNT (index 2) drops by one per unit. The unit that brings it to zero clears CTRL[0] (enable) and sets the sticky done bit STATUS[0] (STATUS is index 4).
- R5: With CTRL[7]=0 (cycle-stealing), `bus_req_o` goes low for at least one cycle after each unit that is not the last. N units give N request rises.
- R6: With CTRL[7]=1 (burst), `bus_req_o` stays high from the first request until the last unit ends. This gives a single request rise.
- R7: STATUS[1] (half) sets on the unit that leaves floor(N/2) units remaining. For N=1 it sets in the same cycle as done.
- R8: `irq_half_o` is STATUS[1] AND CTRL[8], and `irq_done_o` is STATUS[0] AND CTRL[9]. Writing 1 to a STATUS bit clears it, while writing 0 leaves it unchanged.
- R9: An enabling CTRL write is refused if either address is misaligned: not a multiple of 2 for unit code 1, of 4 for code 2, or of 16 for code 3. A refused write sets STATUS[2], leaves CTRL[0] at 0 and raises no bus request.
- R10: Writes to SRC, DST, CNT and CTRL are ignored while CTRL[0] is 1.
- R11: CNT=0 at enable means 16,777,216 units. After the first unit CNT reads 0xFFFFFF and the channel stays enabled.
- R12: With no other input, `bus_req_o` is high two cycles after the clock edge that takes the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| bus_valid_o | output | 1 | Access in progress |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | AW | Access byte address |
| bus_size_o | output | 2 | Access width code |
| bus_wdata_o | output | 32 | Write data, right-justified |
| bus_rdata_i | input | 32 | Read data, right-justified |
| bus_ready_i | input | 1 | Access completes this cycle |
| irq_half_o | output | 1 | Halfway interrupt |
| irq_done_o | output | 1 | Completion interrupt |

## Verification
The halfway mark and the end of the transfer share one clock edge when the count is one. The sweep runs every unit size, address-mode pair and bus policy with counts of 1, 2 and 3, so that collision is hit many times. The bench records how many units had finished when each interrupt first rose and requires 1 and 1 for a single unit. For longer counts it requires N-floor(N/2) and N. A second collision is the set of a sticky bit against software clearing it in the same cycle. There, the set must win, which is judged by reading STATUS after the clear.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int unsigned BUS_DW    = 32;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned BEATS_16  = 4;
  localparam int unsigned CTRL_W    = 10;

  localparam logic [REG_IDX_W-1:0] IDX_SRC  = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_DST  = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_CNT  = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_STAT = 3'd4;

  typedef enum logic [1:0] {SZ_B1 = 2'd0, SZ_B2 = 2'd1, SZ_B4 = 2'd2, SZ_B16 = 2'd3} unit_sz_e;
  typedef enum logic [1:0] {AM_FIX = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2, AM_HOLD = 2'd3} addr_mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_GAP} xfer_st_e;

  typedef struct packed {
    logic       done_ie;
    logic       half_ie;
    logic       burst;
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
    unit_sz_e   size;
    logic       en;
  } ctrl_t;

  function automatic logic [4:0] unit_bytes(unit_sz_e s);
    case (s)
      SZ_B1:   return 5'd1;
      SZ_B2:   return 5'd2;
      SZ_B4:   return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic addr_misaligned(logic [3:0] lsb, unit_sz_e s);
    case (s)
      SZ_B2:   return lsb[0];
      SZ_B4:   return |lsb[1:0];
      SZ_B16:  return |lsb;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  addr_mode_e    mode_i,
  input  unit_sz_e      size_i,
  output logic [AW-1:0] next_o
);

  logic [AW-1:0] step;
  assign step = AW'(unit_bytes(size_i));

  always_comb begin
    case (mode_i)
      AM_INC:  next_o = base_i + step;
      AM_DEC:  next_o = base_i - step;
      default: next_o = base_i;
    endcase
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic [BUS_DW-1:0]    wdata_i,
  output logic [BUS_DW-1:0]    rdata_o,
  input  logic                 unit_done_i,
  output ctrl_t                ctrl_o,
  output logic [AW-1:0]        src_o,
  output logic [AW-1:0]        dst_o,
  output logic [CW-1:0]        cnt_o,
  output logic                 last_o,
  output logic                 half_o,
  output logic                 done_o,
  output logic                 err_o
);

  ctrl_t         ctrl_q, wr_ctrl, ctrl_wr_v;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q, init_q;
  logic          half_q, done_q, err_q;
  logic [CW:0]   rem_after, half_tgt;
  logic          start_bad, wr_ok;
  logic [2:0]    stat_clr;
  logic          set_done, set_half, set_err;

  logic [AW-1:0] step_base [2];
  addr_mode_e    step_mode [2];
  logic [AW-1:0] step_next [2];

  assign step_base[0] = src_q;
  assign step_base[1] = dst_q;
  assign step_mode[0] = ctrl_q.src_mode;
  assign step_mode[1] = ctrl_q.dst_mode;

  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_addr_step #(.AW(AW)) u_step (
      .base_i (step_base[g]),
      .mode_i (step_mode[g]),
      .size_i (ctrl_q.size),
      .next_o (step_next[g])
    );
  end

  assign wr_ok     = we_i && !ctrl_q.en;
  assign wr_ctrl   = ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign start_bad = addr_misaligned(src_q[3:0], wr_ctrl.size) ||
                     addr_misaligned(dst_q[3:0], wr_ctrl.size);

  always_comb begin
    ctrl_wr_v    = wr_ctrl;
    ctrl_wr_v.en = wr_ctrl.en && !start_bad;
  end

  // zero count stands for 2^CW units
  assign rem_after = {cnt_q == '0, cnt_q} - (CW+1)'(1);
  assign half_tgt  = {init_q == '0, init_q} >> 1;
  assign last_o    = (cnt_q == CW'(1));

  assign stat_clr = (we_i && idx_i == IDX_STAT) ? wdata_i[2:0] : 3'b000;
  assign set_done = unit_done_i && last_o;
  assign set_half = unit_done_i && (rem_after == half_tgt);
  assign set_err  = wr_ok && idx_i == IDX_CTRL && wr_ctrl.en && start_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      init_q <= '0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok && idx_i == IDX_SRC) src_q <= wdata_i[AW-1:0];
      if (wr_ok && idx_i == IDX_DST) dst_q <= wdata_i[AW-1:0];
      if (wr_ok && idx_i == IDX_CNT) cnt_q <= wdata_i[CW-1:0];
      if (wr_ok && idx_i == IDX_CTRL) begin
        ctrl_q <= ctrl_wr_v;
        init_q <= cnt_q;
      end
      if (unit_done_i) begin
        cnt_q <= cnt_q - CW'(1);
        src_q <= step_next[0];
        dst_q <= step_next[1];
        if (last_o) ctrl_q.en <= 1'b0;
      end
      // a set in the same cycle as a clear wins
      done_q <= (done_q && !stat_clr[0]) || set_done;
      half_q <= (half_q && !stat_clr[1]) || set_half;
      err_q  <= (err_q  && !stat_clr[2]) || set_err;
    end
  end

  always_comb begin
    case (idx_i)
      IDX_SRC:  rdata_o = BUS_DW'(src_q);
      IDX_DST:  rdata_o = BUS_DW'(dst_q);
      IDX_CNT:  rdata_o = BUS_DW'(cnt_q);
      IDX_CTRL: rdata_o = BUS_DW'(ctrl_q);
      IDX_STAT: rdata_o = BUS_DW'({err_q, half_q, done_q});
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign half_o = half_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              burst_i,
  input  unit_sz_e          size_i,
  input  logic              last_i,
  input  logic              gnt_i,
  input  logic              ready_i,
  input  logic [BUS_DW-1:0] rdata_i,
  output logic              req_o,
  output logic              valid_o,
  output logic              we_o,
  output logic [1:0]        beat_o,
  output logic              unit_done_o,
  output logic [BUS_DW-1:0] data_o
);

  xfer_st_e          st_q, st_d;
  logic [1:0]        beat_q;
  logic [BUS_DW-1:0] data_q;
  logic              beat_last;

  assign beat_last = (size_i != SZ_B16) || (beat_q == 2'(BEATS_16 - 1));

  always_comb begin
    st_d        = st_q;
    req_o       = 1'b0;
    valid_o     = 1'b0;
    we_o        = 1'b0;
    unit_done_o = 1'b0;
    case (st_q)
      ST_IDLE: if (en_i) st_d = ST_REQ;
      ST_REQ: begin
        req_o = 1'b1;
        if (gnt_i) st_d = ST_RD;
      end
      ST_RD: begin
        req_o   = 1'b1;
        valid_o = 1'b1;
        if (ready_i) st_d = ST_WR;
      end
      ST_WR: begin
        req_o   = 1'b1;
        valid_o = 1'b1;
        we_o    = 1'b1;
        if (ready_i) begin
          if (!beat_last) st_d = ST_RD;
          else begin
            unit_done_o = 1'b1;
            if (last_i)       st_d = ST_IDLE;
            else if (burst_i) st_d = ST_RD;
            else              st_d = ST_GAP;
          end
        end
      end
      ST_GAP:  st_d = ST_REQ;   // request low for one cycle
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RD && ready_i) data_q <= rdata_i;
      if (st_q == ST_WR && ready_i) beat_q <= beat_last ? 2'd0 : beat_q + 2'd1;
    end
  end

  assign beat_o = beat_q;
  assign data_o = data_q;

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i,
  input  logic          bus_ready_i,
  output logic          irq_half_o,
  output logic          irq_done_o
);

  ctrl_t         ctrl;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic          last_unit, half_flag, done_flag, err_flag;
  logic          unit_done;
  logic [1:0]    beat;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .idx_i       (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .unit_done_i (unit_done),
    .ctrl_o      (ctrl),
    .src_o       (src),
    .dst_o       (dst),
    .cnt_o       (cnt),
    .last_o      (last_unit),
    .half_o      (half_flag),
    .done_o      (done_flag),
    .err_o       (err_flag)
  );

  dma_chan_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl.en),
    .burst_i     (ctrl.burst),
    .size_i      (ctrl.size),
    .last_i      (last_unit),
    .gnt_i       (bus_gnt_i),
    .ready_i     (bus_ready_i),
    .rdata_i     (bus_rdata_i),
    .req_o       (bus_req_o),
    .valid_o     (bus_valid_o),
    .we_o        (bus_we_o),
    .beat_o      (beat),
    .unit_done_o (unit_done),
    .data_o      (bus_wdata_o)
  );

  assign bus_addr_o = (bus_we_o ? dst : src) + AW'({beat, 2'b00});
  assign bus_size_o = (ctrl.size == SZ_B16) ? SZ_B4 : ctrl.size;
  assign irq_half_o = half_flag && ctrl.half_ie;
  assign irq_done_o = done_flag && ctrl.done_ie;

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req,
  input logic          bus_valid,
  input logic          bus_we,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic          unit_done,
  input logic          last_unit,
  input logic          burst,
  input logic          en,
  input logic          done_flag,
  input logic [CW-1:0] cnt
);

  p_access_owned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid |-> bus_req);

  p_access_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));

  p_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid |-> !((bus_size == 2'd2 && bus_addr[1:0] != 2'd0) ||
                    (bus_size == 2'd1 && bus_addr[0])));

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_done |=> cnt == $past(cnt) - CW'(1));

  p_end_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_done && last_unit |=> !en && done_flag);

  p_steal_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_done && !last_unit && !burst |=> !bus_req);

  p_burst_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_done && !last_unit && burst |=> bus_req);

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_req   (bus_req_o),
  .bus_valid (bus_valid_o),
  .bus_we    (bus_we_o),
  .bus_ready (bus_ready_i),
  .bus_addr  (bus_addr_o),
  .bus_size  (bus_size_o),
  .unit_done (unit_done),
  .last_unit (last_unit),
  .burst     (ctrl.burst),
  .en        (ctrl.en),
  .done_flag (done_flag),
  .cnt       (cnt)
);

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req, bus_gnt, bus_valid, bus_we, bus_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        irq_half, irq_done;

  always #2 clk = ~clk;

  dma_chan_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .bus_req_o(bus_req),
    .bus_gnt_i(bus_gnt), .bus_valid_o(bus_valid), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_size_o(bus_size), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready),
    .irq_half_o(irq_half), .irq_done_o(irq_done)
  );

  // behavioural memory with its own grant and ready
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic       init_go = 1'b0;
  int         init_seed = 0;
  logic [7:0] a0;
  assign a0 = bus_addr[7:0];
  assign bus_rdata = {mem[a0 + 8'd3], mem[a0 + 8'd2], mem[a0 + 8'd1], mem[a0]};

  initial begin bus_gnt = 1'b0; bus_ready = 1'b0; end

  always @(posedge clk) begin
    bus_gnt   <= bus_req;
    bus_ready <= bus_valid && !bus_ready;
    if (init_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + init_seed * 11 + 5);
    end else if (bus_valid && bus_ready && bus_we) begin
      for (int i = 0; i < 4; i++)
        if (i < (bus_size == 2'd0 ? 1 : bus_size == 2'd1 ? 2 : 4))
          mem[a0 + 8'(i)] <= bus_wdata[8*i +: 8];
    end
  end

  // run parameters used by the access monitor
  int cur_sz, cur_sm, cur_dm, cur_n;
  int cur_sb, cur_db;

  function automatic int dlt(int mode, int ub);
    return mode == 1 ? ub : (mode == 2 ? -ub : 0);
  endfunction
  function automatic int ubytes(int sz);
    return sz == 0 ? 1 : sz == 1 ? 2 : sz == 2 ? 4 : 16;
  endfunction
  function automatic int per_unit();
    return cur_sz == 3 ? 8 : 2;
  endfunction
  function automatic logic [31:0] exp_addr(int k);
    int u, r, base;
    u = k / per_unit();
    r = k % per_unit();
    if (r % 2 == 1) base = cur_db + dlt(cur_dm, ubytes(cur_sz)) * u;
    else            base = cur_sb + dlt(cur_sm, ubytes(cur_sz)) * u;
    return 32'(base + 4 * (r / 2));
  endfunction

  logic mon_clr = 1'b0;
  logic req_prev = 1'b0;
  int   acc_k, acc_err, units_seen, req_rises, half_at, done_at;

  always @(posedge clk) begin
    req_prev <= bus_req;
    if (mon_clr) begin
      acc_k <= 0; acc_err <= 0; units_seen <= 0; req_rises <= 0;
      half_at <= -1; done_at <= -1;
    end else begin
      if (bus_req && !req_prev) req_rises <= req_rises + 1;
      if (bus_valid && bus_ready) begin
        acc_k <= acc_k + 1;
        if (bus_addr != exp_addr(acc_k) || bus_we != (acc_k % 2 == 1) ||
            bus_size != 2'(cur_sz == 3 ? 2 : cur_sz))
          acc_err <= acc_err + 1;
        if (bus_we && (acc_k % per_unit()) == per_unit() - 1) units_seen <= units_seen + 1;
      end
      if (irq_half && half_at < 0) half_at <= units_seen;
      if (irq_done && done_at < 0) done_at <= units_seen;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = idx;
    #1 d = reg_rdata;
  endtask

  task automatic mon_reset(input int seed);
    @(negedge clk);
    mon_clr = 1'b1; init_go = 1'b1; init_seed = seed;
    @(negedge clk);
    mon_clr = 1'b0; init_go = 1'b0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + seed * 11 + 5);
  endtask

  function automatic logic [31:0] ctrl_word(int sz, int sm, int dm, int bu, int ie, int en);
    return 32'((ie << 8) | (ie << 9) | (bu << 7) | (dm << 5) | (sm << 3) | (sz << 1) | en);
  endfunction

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      if (irq_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_case(input int sz, input int sm, input int dm, input int bu, input int n);
    logic [31:0] d;
    bit ok;
    int ub, mism;
    string tag;
    tag = $sformatf("sz%0d sm%0d dm%0d b%0d n%0d", sz, sm, dm, bu, n);
    cur_sz = sz; cur_sm = sm; cur_dm = dm; cur_n = n;
    cur_sb = 32'h30; cur_db = 32'hC0;
    ub = ubytes(sz);
    mon_reset(sz * 31 + sm * 7 + dm * 3 + bu + n);
    for (int u = 0; u < n; u++)
      for (int i = 0; i < ub; i++)
        exp_mem[8'(cur_db + dlt(dm, ub) * u + i)] = exp_mem[8'(cur_sb + dlt(sm, ub) * u + i)];
    wr_reg(3'd0, 32'(cur_sb));
    wr_reg(3'd1, 32'(cur_db));
    wr_reg(3'd2, 32'(n));
    wr_reg(3'd3, ctrl_word(sz, sm, dm, bu, 1, 1));
    wait_done(ok);
    chk(ok, "R4", {"done irq ", tag}, 32'(ok), 32'd1);
    repeat (2) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, "R2", {"memory image ", tag}, 32'(mism), 32'd0);
    chk(acc_err == 0 && acc_k == n * per_unit(), "R2", {"access trace ", tag},
        32'(acc_k - 1000 * acc_err), 32'(n * per_unit()));
    rd_reg(3'd0, d);
    chk(d == 32'(cur_sb + dlt(sm, ub) * n), "R3", {"final SRC ", tag}, d, 32'(cur_sb + dlt(sm, ub) * n));
    rd_reg(3'd1, d);
    chk(d == 32'(cur_db + dlt(dm, ub) * n), "R3", {"final DST ", tag}, d, 32'(cur_db + dlt(dm, ub) * n));
    rd_reg(3'd2, d);
    chk(d == 32'd0, "R4", {"final CNT ", tag}, d, 32'd0);
    rd_reg(3'd3, d);
    chk(d == ctrl_word(sz, sm, dm, bu, 1, 0), "R4", {"enable cleared ", tag}, d, ctrl_word(sz, sm, dm, bu, 1, 0));
    if (bu == 0) chk(req_rises == n, "R5", {"request rises ", tag}, 32'(req_rises), 32'(n));
    else         chk(req_rises == 1, "R6", {"request rises ", tag}, 32'(req_rises), 32'd1);
    chk(half_at == n - n / 2, "R7", {"half point ", tag}, 32'(half_at), 32'(n - n / 2));
    chk(done_at == n, "R7", {"done point ", tag}, 32'(done_at), 32'(n));
    wr_reg(3'd4, 32'h3);
    rd_reg(3'd4, d);
    chk(d == 32'd0 && !irq_half && !irq_done, "R8", {"W1C clear ", tag},
        {d[29:0], irq_half, irq_done}, 32'd0);
  endtask

  task automatic misalign_case(input int sz, input int sb, input int db);
    logic [31:0] d;
    cur_sz = sz;
    mon_reset(1);
    wr_reg(3'd0, 32'(sb));
    wr_reg(3'd1, 32'(db));
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd3, ctrl_word(sz, 1, 1, 0, 1, 1));
    repeat (8) @(negedge clk);
    rd_reg(3'd4, d);
    chk(d == 32'h4, "R9", $sformatf("error flag sz%0d", sz), d, 32'h4);
    rd_reg(3'd3, d);
    chk(d[0] == 1'b0, "R9", $sformatf("enable refused sz%0d", sz), d, ctrl_word(sz, 1, 1, 0, 1, 0));
    chk(req_rises == 0, "R9", $sformatf("no request sz%0d", sz), 32'(req_rises), 32'd0);
    wr_reg(3'd4, 32'h4);
  endtask

  initial begin
    logic [31:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 5; i++) begin
      rd_reg(3'(i), d);
      chk(d == 32'd0, "R1", $sformatf("reg %0d after reset", i), d, 32'd0);
    end
    chk(!bus_req && !bus_valid && !irq_half && !irq_done, "R1", "outputs after reset",
        {28'd0, bus_req, bus_valid, irq_half, irq_done}, 32'd0);

    // R9: misaligned starts
    misalign_case(1, 32'h30, 32'hC1);
    misalign_case(2, 32'h32, 32'hC0);
    misalign_case(3, 32'h38, 32'hC0);

    // R2 R3 R4 R5 R6 R7 R8: full sweep
    for (int sz = 0; sz < 4; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++)
          for (int bu = 0; bu < 2; bu++)
            for (int n = 1; n < 4; n++)
              run_case(sz, sm, dm, bu, n);

    // R10: configuration writes while enabled
    cur_sz = 3; cur_sm = 1; cur_dm = 1; cur_sb = 32'h30; cur_db = 32'hC0;
    mon_reset(9);
    wr_reg(3'd0, 32'h30);
    wr_reg(3'd1, 32'hC0);
    wr_reg(3'd2, 32'd3);
    wr_reg(3'd3, ctrl_word(3, 1, 1, 1, 1, 1));
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd2, 32'd7);
    wr_reg(3'd3, 32'd0);
    wait_done(ok);
    repeat (2) @(negedge clk);
    rd_reg(3'd0, d);
    chk(d == 32'h60, "R10", "SRC write ignored", d, 32'h60);
    chk(acc_k == 24, "R10", "CNT write ignored", 32'(acc_k), 32'd24);
    rd_reg(3'd3, d);
    chk(d == ctrl_word(3, 1, 1, 1, 1, 0), "R10", "CTRL write ignored", d, ctrl_word(3, 1, 1, 1, 1, 0));
    wr_reg(3'd4, 32'h3);

    // R8: masked interrupts, partial clear, set-vs-clear collision
    cur_sz = 0; cur_sm = 1; cur_dm = 1;
    mon_reset(4);
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd3, ctrl_word(0, 1, 1, 0, 0, 1));
    repeat (20) @(negedge clk);
    rd_reg(3'd4, d);
    chk(d == 32'h3 && !irq_half && !irq_done, "R8", "masked flags",
        {d[29:0], irq_half, irq_done}, 32'hC);
    wr_reg(3'd3, ctrl_word(0, 1, 1, 0, 1, 0));
    chk(irq_half && irq_done, "R8", "unmasked irqs", {30'd0, irq_half, irq_done}, 32'd3);
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, d);
    chk(d == 32'h2 && irq_half && !irq_done, "R8", "clear done only", d, 32'h2);
    // R7: done sets on the edge where software clears it; set wins
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd3, ctrl_word(0, 1, 1, 1, 1, 1));
    @(negedge clk);
    while (!(bus_valid && bus_we && bus_ready)) @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h3;
    @(negedge clk);
    reg_we = 1'b0;
    rd_reg(3'd4, d);
    chk(d == 32'h3, "R7", "set wins over clear", d, 32'h3);
    wr_reg(3'd4, 32'h3);

    // R11 R12: zero count means full range, self-started request
    cur_sz = 2;
    mon_reset(5);
    wr_reg(3'd0, 32'h30);
    wr_reg(3'd1, 32'hC0);
    wr_reg(3'd2, 32'd0);
    wr_reg(3'd3, ctrl_word(2, 1, 1, 0, 1, 1));
    chk(!bus_req, "R12", "request not yet up", {31'd0, bus_req}, 32'd0);
    @(negedge clk);
    chk(bus_req, "R12", "auto request", {31'd0, bus_req}, 32'd1);
    d = 32'd0;
    for (int t = 0; t < 200 && d == 32'd0; t++) rd_reg(3'd2, d);
    chk(d == 32'hFFFFFF, "R11", "count after first unit", d, 32'hFFFFFF);
    rd_reg(3'd3, d);
    chk(d[0] == 1'b1, "R11", "still enabled", d, ctrl_word(2, 1, 1, 0, 1, 1));
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(3'd3, d);
    chk(d == 32'd0, "R1", "CTRL after second reset", d, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule